// File: doc/BRIEF.md
# Double-Buffered Isochronous IN Endpoint

This block is the transmit half of one isochronous IN endpoint. A producer (firmware or a DMA engine) pushes bytes through a byte write port into two packet buffers that are used in strict alternation. A buffer becomes ready to send, or committed, in one of two ways:

- its last byte slot is filled, or
- software sets the short-packet bit in the control/status register, which sends whatever is in the buffer, including nothing.

When the serial engine presents an IN token, the block does one of three things:

- If a committed buffer is waiting, it streams that buffer's bytes over a valid/ready byte handshake.
- If the waiting packet is zero-length, it signals that packet at once.
- If nothing is committed, it either answers with NAK or records an underrun, depending on the completion flag.

Software sees a single 8-bit control/status register with these bits:

- a buffer-service flag;
- a sent-packet flag that is cleared by writing 1;
- a flush command;
- an underrun flag that is cleared by writing 1;
- the short-packet commit bit.

An interrupt request combines the sent-packet flag, gated by an enable input, with the underrun flag. The enable input lets a DMA-driven producer stream packets without interrupts. A configuration-event input pulse flushes the buffers in the same way as the software flush.

Top module: `dbuf_in_ep`

## Requirements
- R1: A buffer commits by itself when PKT_BYTES bytes (default 256) have been written into it. The commit uses no short-packet write, and the short-packet bit (bit 7) then reads 0.
- R2: Writing 1 to bit 7 commits the current buffer with the number of bytes written so far, which may be 0. A committed packet of length 0 is answered in its token cycle with tx_zlp and sends no byte.
- R3: Bit 0 (service) reads 1 while at most one buffer is committed, and reads 0 while both are committed.
- R4: Bit 1 (sent) is set in the cycle after a packet's last byte is accepted, or after a zero-length packet is signalled. Writing 1 to bit 1 clears it. If the set and the clear fall in the same cycle, the set wins.
- R5: When bit 1 is set and no buffer is committed, an IN token gets tx_nak in the token cycle. A set bit 1 does not stop a committed buffer from being sent.
- R6: An IN token that finds no committed buffer while bit 1 is clear sets bit 3 (underrun) and sends nothing. Writing 1 to bit 3 clears it.
- R7: irq equals (bit 1 AND tx_ien) OR bit 3.
- R8: Writing 1 to bit 2, or a pulse on cfg_event, empties both buffers, resets both buffer pointers to the first buffer and clears bit 7. It leaves bits 1 and 3 unchanged. Bit 2 always reads 0.
- R9: Register bits 6:4 read 0, and writing them changes nothing.
- R10: Buffers are filled and sent in alternating order. Each packet's bytes leave in the order they were written, one per cycle in which tx_valid and tx_ready are both high, and tx_last marks the final byte.
- R11: Bit 7 reads 1 from a short-packet commit until the packet it committed has been sent.
- R12: Bytes written while both buffers are committed are dropped.
- R13: A byte written in the same cycle as a short-packet commit belongs to the packet being committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to store |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write value |
| reg_rdata | output | 8 | Register read value |
| cfg_event | input | 1 | Configuration-change pulse (flushes buffers) |
| tx_ien | input | 1 | Enable for the sent-packet interrupt |
| tok_in | input | 1 | IN token pulse from the serial engine |
| tx_nak | output | 1 | NAK response, in the token cycle |
| tx_zlp | output | 1 | Zero-length packet response, in the token cycle |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | DATA_W | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Serial engine accepts the byte |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same clock edge, and each pair is driven deliberately.

The first pair is a packet completing while software writes 1 to clear bit 1. The bench sends a one-byte packet and raises the clearing write exactly in the cycle its last byte is accepted. It then expects bit 1 to stay set.

The second pair is a byte write and a short-packet commit in one cycle. The bench presents the third byte of a packet together with the bit 7 write. It then expects the packet to leave with three bytes, ending with that byte.

// File: rtl/ep_in_pkg.sv
package ep_in_pkg;
   typedef enum logic {ST_IDLE, ST_SEND} drain_st_t;
   localparam int B_SVC   = 0;
   localparam int B_SENT  = 1;
   localparam int B_FLUSH = 2;
   localparam int B_UNDER = 3;
   localparam int B_SHORT = 7;
endpackage

// File: rtl/ep_fill.sv
module ep_fill #(
   parameter int PKT_BYTES = 256,
   parameter int CNT_W     = 9,
   parameter int AW        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_valid,
   input  logic             short_req,
   input  logic             rel,
   input  logic             rel_sel,
   output logic             we,
   output logic             wsel,
   output logic [AW-1:0]    waddr,
   output logic [1:0]       cm,
   output logic [CNT_W-1:0] len0,
   output logic [CNT_W-1:0] len1,
   output logic             commit,
   output logic             commit_sel
);
   logic [1:0]       cm_q;
   logic             sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q [2];
   logic [CNT_W-1:0] cnt_n;
   logic             accept, full;

   assign accept     = wr_valid && !cm_q[sel_q];
   assign cnt_n      = cnt_q + CNT_W'(accept);
   assign full       = accept && (cnt_q == CNT_W'(PKT_BYTES - 1));
   assign commit     = !cm_q[sel_q] && (full || short_req);
   assign commit_sel = sel_q;
   assign we         = accept;
   assign wsel       = sel_q;
   assign waddr      = cnt_q[AW-1:0];
   assign cm         = cm_q;
   assign len0       = len_q[0];
   assign len1       = len_q[1];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         cm_q  <= '0;
         sel_q <= 1'b0;
         cnt_q <= '0;
         for (int i = 0; i < 2; i++) len_q[i] <= '0;
      end else begin
         if (rel) cm_q[rel_sel] <= 1'b0;
         if (commit) begin
            cm_q[sel_q]  <= 1'b1;
            len_q[sel_q] <= cnt_n;
            sel_q        <= ~sel_q;
            cnt_q        <= '0;
         end else begin
            cnt_q <= cnt_n;
         end
      end
   end
endmodule

// File: rtl/ep_bufmem.sv
module ep_bufmem #(
   parameter int PKT_BYTES = 256,
   parameter int DATA_W    = 8,
   parameter int AW        = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic              wsel,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rsel,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] bank_rd [2];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [DATA_W-1:0] mem [PKT_BYTES];
      always_ff @(posedge clk) begin
         if (we && (wsel == 1'(b))) mem[waddr] <= wdata;
      end
      assign bank_rd[b] = mem[raddr];
   end

   assign rdata = bank_rd[rsel];
endmodule

// File: rtl/ep_drain.sv
module ep_drain
   import ep_in_pkg::*;
#(
   parameter int CNT_W = 9,
   parameter int AW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             tok_in,
   input  logic [1:0]       cm,
   input  logic [CNT_W-1:0] len0,
   input  logic [CNT_W-1:0] len1,
   input  logic             sent_flag,
   input  logic             tx_ready,
   output logic             rd_sel,
   output logic [AW-1:0]    raddr,
   output logic             tx_valid,
   output logic             tx_last,
   output logic             tx_nak,
   output logic             tx_zlp,
   output logic             done,
   output logic             underrun
);
   drain_st_t        st_q;
   logic             sel_q;
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] cur_len;
   logic             avail, idle_tok;

   assign cur_len  = sel_q ? len1 : len0;
   assign avail    = cm[sel_q];
   assign idle_tok = (st_q == ST_IDLE) && tok_in;
   assign tx_zlp   = idle_tok && avail && (cur_len == '0);
   assign tx_nak   = idle_tok && !avail && sent_flag;
   assign underrun = idle_tok && !avail && !sent_flag;
   assign tx_valid = (st_q == ST_SEND);
   assign tx_last  = tx_valid && (idx_q == cur_len - CNT_W'(1));
   assign done     = tx_zlp || (tx_valid && tx_ready && tx_last);
   assign rd_sel   = sel_q;
   assign raddr    = idx_q[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         st_q  <= ST_IDLE;
         sel_q <= 1'b0;
         idx_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (tx_zlp) begin
                  sel_q <= ~sel_q;
               end else if (idle_tok && avail) begin
                  st_q  <= ST_SEND;
                  idx_q <= '0;
               end
            end
            default: begin
               if (tx_ready) begin
                  if (tx_last) begin
                     st_q  <= ST_IDLE;
                     sel_q <= ~sel_q;
                     idx_q <= '0;
                  end else begin
                     idx_q <= idx_q + CNT_W'(1);
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/dbuf_in_ep.sv
module dbuf_in_ep
   import ep_in_pkg::*;
#(
   parameter int PKT_BYTES = 256,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              cfg_event,
   input  logic              tx_ien,
   input  logic              tok_in,
   output logic              tx_nak,
   output logic              tx_zlp,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              irq
);
   localparam int CNT_W = $clog2(PKT_BYTES + 1);
   localparam int AW    = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1;

   if (PKT_BYTES < 2) begin : g_bad_pkt
      $error("PKT_BYTES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end

   logic             flush_w, short_w, done_w, under_w;
   logic             we, wsel, commit, commit_sel, rd_sel;
   logic [AW-1:0]    waddr, raddr;
   logic [1:0]       cm;
   logic [CNT_W-1:0] len0, len1;
   logic             sent_q, under_q, short_q, short_buf_q;

   assign flush_w = cfg_event || (reg_wr && reg_wdata[B_FLUSH]);
   assign short_w = reg_wr && reg_wdata[B_SHORT] && !flush_w;

   ep_fill #(.PKT_BYTES(PKT_BYTES), .CNT_W(CNT_W), .AW(AW)) u_fill (
      .clk(clk), .rst_n(rst_n), .flush(flush_w), .wr_valid(wr_valid),
      .short_req(short_w), .rel(done_w), .rel_sel(rd_sel),
      .we(we), .wsel(wsel), .waddr(waddr), .cm(cm), .len0(len0), .len1(len1),
      .commit(commit), .commit_sel(commit_sel)
   );

   ep_bufmem #(.PKT_BYTES(PKT_BYTES), .DATA_W(DATA_W), .AW(AW)) u_mem (
      .clk(clk), .we(we), .wsel(wsel), .waddr(waddr), .wdata(wr_data),
      .rsel(rd_sel), .raddr(raddr), .rdata(tx_data)
   );

   ep_drain #(.CNT_W(CNT_W), .AW(AW)) u_drain (
      .clk(clk), .rst_n(rst_n), .flush(flush_w), .tok_in(tok_in), .cm(cm),
      .len0(len0), .len1(len1), .sent_flag(sent_q), .tx_ready(tx_ready),
      .rd_sel(rd_sel), .raddr(raddr), .tx_valid(tx_valid), .tx_last(tx_last),
      .tx_nak(tx_nak), .tx_zlp(tx_zlp), .done(done_w), .underrun(under_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sent_q      <= 1'b0;
         under_q     <= 1'b0;
         short_q     <= 1'b0;
         short_buf_q <= 1'b0;
      end else begin
         if (done_w)                              sent_q <= 1'b1;
         else if (reg_wr && reg_wdata[B_SENT])    sent_q <= 1'b0;
         if (under_w)                             under_q <= 1'b1;
         else if (reg_wr && reg_wdata[B_UNDER])   under_q <= 1'b0;
         if (flush_w) begin
            short_q <= 1'b0;
         end else if (commit && short_w) begin
            short_q     <= 1'b1;
            short_buf_q <= commit_sel;
         end else if (done_w && (rd_sel == short_buf_q)) begin
            short_q <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata          = '0;
      reg_rdata[B_SVC]   = !(cm[0] && cm[1]);
      reg_rdata[B_SENT]  = sent_q;
      reg_rdata[B_UNDER] = under_q;
      reg_rdata[B_SHORT] = short_q;
   end

   assign irq = (sent_q && tx_ien) || under_q;
endmodule

// File: rtl/dbuf_in_ep_chk.sv
module dbuf_in_ep_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] reg_rdata,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic       tok_in,
   input logic       tx_ien,
   input logic       tx_nak,
   input logic       tx_valid,
   input logic       irq,
   input logic       done_w,
   input logic       flush_w
);
   p_tpc_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_w |=> reg_rdata[1]);
   p_tpc_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[1] && !done_w) |=> !reg_rdata[1]);
   p_nak_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_nak |-> (reg_rdata[1] && !tx_valid));
   p_tur_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[3]) |-> $past(tok_in));
   p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq == ((reg_rdata[1] && tx_ien) || reg_rdata[3]));
   p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_w |=> (reg_rdata[0] && !tx_valid && !reg_rdata[7]));
   p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[6:4] == 3'b000) && !reg_rdata[2]);
endmodule

bind dbuf_in_ep dbuf_in_ep_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .tok_in(tok_in), .tx_ien(tx_ien), .tx_nak(tx_nak),
   .tx_valid(tx_valid), .irq(irq), .done_w(done_w), .flush_w(flush_w)
);

// File: tb/dbuf_in_ep_tb.sv
`timescale 1ns/1ps
module dbuf_in_ep_tb;
   localparam int PKT = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       cfg_event = 1'b0;
   logic       tx_ien = 1'b0;
   logic       tok_in = 1'b0;
   logic       tx_nak, tx_zlp, tx_valid, tx_last, irq;
   logic [7:0] tx_data;
   logic       tx_ready = 1'b1;

   int         n_run = 0;
   int         n_fail = 0;
   bit         reported = 0;
   logic [7:0] rx [PKT + 4];
   bit         last_seen;
   int         n;
   bit         nk, zl;

   always #4 clk = ~clk;

   dbuf_in_ep #(.PKT_BYTES(PKT), .DATA_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cfg_event(cfg_event), .tx_ien(tx_ien), .tok_in(tok_in),
      .tx_nak(tx_nak), .tx_zlp(tx_zlp), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int k, input int i);
      return 8'(k * 17 + i * 3 + 1);
   endfunction

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic put(input logic [7:0] d);
      wr_valid = 1'b1; wr_data = d; step(); wr_valid = 1'b0;
   endtask

   task automatic csr(input logic [7:0] v);
      reg_wr = 1'b1; reg_wdata = v; step(); reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic token();
      tok_in = 1'b1; #1;
      nk = tx_nak; zl = tx_zlp;
      step(); tok_in = 1'b0;
      n = 0; last_seen = 0;
      while (tx_valid && n < PKT + 2) begin
         rx[n] = tx_data;
         last_seen = tx_last;
         n++;
         step();
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      chk(reg_rdata == 8'h01, "R3 reset value", reg_rdata, 8'h01);
      chk(!irq && !tx_valid, "R7 reset irq", irq, 0);

      // Sweep every packet length with the interrupt enabled
      tx_ien = 1'b1;
      for (int L = 0; L <= PKT; L++) begin
         for (int i = 0; i < L; i++) put(pat(L, i));
         if (L < PKT) begin
            csr(8'h80);
            chk(reg_rdata[7] == 1'b1, "R11 short bit set", reg_rdata[7], 1);
         end else begin
            chk(reg_rdata[7] == 1'b0, "R1 auto commit no short bit", reg_rdata[7], 0);
         end
         chk(reg_rdata[0] == 1'b1, "R3 one buffer committed", reg_rdata[0], 1);
         token();
         chk(zl == (L == 0), "R2 zero-length response", zl, L == 0);
         chk(!nk, "R5 no nak with data", nk, 0);
         chk(n == L, "R2 byte count", n, L);
         for (int i = 0; i < L && i < n; i++)
            chk(rx[i] == pat(L, i), "R10 byte order", rx[i], pat(L, i));
         if (L > 0) chk(last_seen, "R10 last flag", last_seen, 1);
         chk(reg_rdata[1] == 1'b1, "R4 sent flag set", reg_rdata[1], 1);
         chk(reg_rdata[7] == 1'b0, "R11 short bit cleared", reg_rdata[7], 0);
         chk(irq == 1'b1, "R7 irq on sent", irq, 1);
         csr(8'h02);
         chk(reg_rdata[1] == 1'b0, "R4 w1c", reg_rdata[1], 0);
         chk(irq == 1'b0, "R7 irq cleared", irq, 0);
      end

      // Ping-pong, both full, dropped byte, same-cycle byte plus short commit
      tx_ien = 1'b0;
      for (int i = 0; i < PKT; i++) put(pat(20, i));
      put(pat(21, 0)); put(pat(21, 1));
      wr_valid = 1'b1; wr_data = pat(21, 2); reg_wr = 1'b1; reg_wdata = 8'h80;
      step(); wr_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      chk(reg_rdata[0] == 1'b0, "R3 both committed", reg_rdata[0], 0);
      put(8'hEE);
      token();
      chk(n == PKT && rx[0] == pat(20, 0) && rx[PKT-1] == pat(20, PKT-1),
          "R10 first buffer first", n, PKT);
      chk(reg_rdata[0] == 1'b1, "R3 service after send", reg_rdata[0], 1);
      token();
      chk(!nk && n == 3, "R5 send despite sent flag", n, 3);
      chk(rx[2] == pat(21, 2), "R13 same-cycle byte kept", rx[2], pat(21, 2));
      token();
      chk(nk == 1'b1 && n == 0, "R5 nak when empty", nk, 1);
      chk(reg_rdata[3] == 1'b0, "R6 no underrun while sent set", reg_rdata[3], 0);
      csr(8'h80);
      token();
      chk(zl == 1'b1 && n == 0, "R12 dropped byte not queued", n, 0);
      csr(8'h02);
      token();
      chk(!nk && n == 0 && reg_rdata[3] == 1'b1, "R6 underrun set", reg_rdata[3], 1);
      chk(irq == 1'b1, "R7 irq on underrun", irq, 1);
      csr(8'h08);
      chk(reg_rdata[3] == 1'b0 && !irq, "R6 underrun w1c", reg_rdata[3], 0);

      // Flush by register write
      put(8'h11); put(8'h12); csr(8'h80); put(8'h13);
      csr(8'h04);
      chk(reg_rdata == 8'h01, "R8 flush register state", reg_rdata, 8'h01);
      token();
      chk(n == 0 && reg_rdata[3] == 1'b1, "R8 flush emptied buffers", n, 0);
      csr(8'h08);

      // Flush by configuration event, then refill
      put(8'h21); put(8'h22); csr(8'h80);
      cfg_event = 1'b1; step(); cfg_event = 1'b0;
      chk(reg_rdata[7] == 1'b0, "R8 cfg event clears short", reg_rdata[7], 0);
      put(8'h5A); csr(8'h80);
      token();
      chk(n == 1 && rx[0] == 8'h5A, "R8 cfg event reset pointers", rx[0], 8'h5A);
      csr(8'h04);
      chk(reg_rdata[1] == 1'b1, "R8 flush keeps sent flag", reg_rdata[1], 1);
      csr(8'h02);

      // Reserved bits
      csr(8'h70);
      chk(reg_rdata == 8'h01, "R9 reserved bits", reg_rdata, 8'h01);

      // Completion and clear in the same cycle
      put(8'h77); csr(8'h80);
      tok_in = 1'b1; step(); tok_in = 1'b0;
      chk(tx_valid && tx_last, "R10 single byte last", tx_last, 1);
      reg_wr = 1'b1; reg_wdata = 8'h02; step(); reg_wr = 1'b0; reg_wdata = '0;
      chk(reg_rdata[1] == 1'b1, "R4 set wins over clear", reg_rdata[1], 1);
      chk(!tx_valid, "R10 send ended", tx_valid, 0);

      report();
   end
endmodule